// File: doc/BRIEF.md
# Two-Channel Positioned Audio Shifter

This block moves two audio channels per frame between 32-bit sample words and a serial data line. An external timing generator supplies the running bit count of the frame, together with one strobe for launching transmit bits and one for sampling receive bits. Each channel has its own start position within the frame and its own sample width. The transmit side pulls sample words from an upstream source and shifts them out MSB first. The receive side assembles incoming bits into words and presents them with a one-cycle valid strobe.

Two 16-bit channels can share one 32-bit word. When this packed mode is on, the transmit side fetches one word per frame and splits it. The receive side emits one combined word per frame. Transmit and receive each have their own configuration word and their own packed enable, so the two directions can use different layouts.

Each channel is handled by a lane with a two-state machine. In `L_IDLE` the lane holds the line low, or captures nothing on the receive side. It takes the *start* transition to `L_SHIFT` on the strobe where the bit count equals the channel position. In `L_SHIFT` it moves one bit per strobe. The *finish* transition returns it to `L_IDLE` once the last bit is done. A start that arrives while the lane is still in `L_SHIFT` reloads the lane and keeps it in `L_SHIFT` (the *restart* transition).

Top module: `pos_audio_shifter`

## Requirements
- R1: A configuration word carries channel 1 in bits [31:16] and channel 2 in bits [15:0]. The transmit and receive configuration words are decoded the same way.
- R2: Within each 16-bit half, the bit fields are as follows:
  - width code: bits [3:0]
  - start position: bits [13:4]
  - channel enable: bit 14
  - width extension: bit 15
- R3: Channel width is 8 plus the width code, plus 16 more when the extension bit is set. A result above 32 is limited to 32.
- R4: On the transmit side, a channel starts on the launch strobe where the bit count equals its position. From the cycle after that strobe, `sdo` carries bit width-1 of the sample. Each later launch strobe moves to the next lower bit. Only the low `width` bits of the sample are sent.
- R5: The line is low on every bit that no enabled channel covers. A disabled transmit channel never drives the line.
- R6: On the receive side, an enabled channel captures `sdi` on `width` consecutive sample strobes, starting at the strobe where the bit count equals its position. Bits arrive MSB first. In unpacked mode, each channel produces one `rx_valid` pulse. The word carries the sample in its low `width` bits, with zeros above.
- R7: A disabled receive channel captures nothing and produces no `rx_valid` pulse.
- R8: In transmit packed mode, one word is fetched per frame, at the start of whichever enabled channel has the lower position. Channel 1 sends from bits [15:0] of that word and channel 2 from bits [31:16]. In unpacked mode, each channel start fetches its own word.
- R9: In receive packed mode, one word is emitted per frame, after the last enabled channel completes. Channel 1 goes to bits [15:0] and channel 2 to bits [31:16]. When only one channel is enabled, the other half is zero.
- R10: A word is taken (`tx_take` high before the edge) only while `tx_word_valid` is high. If a channel start needs a word and none is offered, zeros are sent for that word. In that case `tx_underrun` pulses high for one cycle and nothing is taken.
- R11: The transmit and receive settings are independent: packed mode and channel layout on one side do not affect the other side.
- R12: After reset, `sdo`, `rx_valid`, `tx_underrun` and `tx_take` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_cnt | input | 10 | Bit count since frame start |
| tx_edge | input | 1 | Launch strobe for transmit bits |
| rx_edge | input | 1 | Sample strobe for receive bits |
| tx_cfg | input | 32 | Transmit channel configuration |
| rx_cfg | input | 32 | Receive channel configuration |
| tx_pack | input | 1 | Transmit packed-mode enable |
| rx_pack | input | 1 | Receive packed-mode enable |
| tx_word | input | 32 | Offered transmit sample word |
| tx_word_valid | input | 1 | Transmit word is available |
| tx_take | output | 1 | Transmit word consumed at this edge |
| tx_underrun | output | 1 | One-cycle pulse: a channel start found no word |
| sdo | output | 1 | Serial transmit data |
| sdi | input | 1 | Serial receive data |
| rx_word | output | 32 | Received sample word |
| rx_valid | output | 1 | One-cycle strobe, `rx_word` is new |

## Verification
The bench builds the block with the default parameters: a 32-bit word, 16-bit halves and a 10-bit position field. It runs 64-bit frames with one strobe every two clocks. These values allow a full 32-bit channel and the clamped over-range width code. They also allow packed frames in which either channel comes first, and frames that mix packed transmit with unpacked receive. The line is checked bit by bit against a model built from the field layout, together with word counts, underrun pulses and every received word.

// File: rtl/pas_pkg.sv
`timescale 1ns/1ps
package pas_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int POS_W   = 10;
    localparam int CODE_W  = 4;
    localparam int WID_W   = $clog2(WORD_W) + 1;
    localparam int MIN_W   = 8;
    localparam int EXT_ADD = 16;
    localparam int N_CH    = 2;

    typedef struct packed {
        logic              ext;
        logic              en;
        logic [POS_W-1:0]  pos;
        logic [CODE_W-1:0] code;
    } chan_cfg_t;

    typedef enum logic {
        L_IDLE,
        L_SHIFT
    } lane_state_e;

    function automatic logic [WID_W-1:0] chan_width(chan_cfg_t c);
        logic [WID_W:0] w;
        w = (WID_W+1)'(MIN_W) + (WID_W+1)'(c.code) +
            (c.ext ? (WID_W+1)'(EXT_ADD) : '0);
        if (w > (WID_W+1)'(WORD_W)) w = (WID_W+1)'(WORD_W);
        return w[WID_W-1:0];
    endfunction
endpackage

// File: rtl/pas_tx_lane.sv
`timescale 1ns/1ps
module pas_tx_lane
    import pas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              start_i,
    input  logic [WID_W-1:0]  width_i,
    input  logic [WORD_W-1:0] sample_i,
    output logic              bit_o
);
    lane_state_e       state, nxt;
    logic [WORD_W-1:0] shreg;
    logic [WID_W-1:0]  rem;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= L_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            L_IDLE:  if (start_i) nxt = L_SHIFT;
            L_SHIFT: if (edge_i && !start_i && rem == '0) nxt = L_IDLE;
            default: nxt = L_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            rem   <= '0;
        end else if (start_i) begin
            shreg <= sample_i << (WID_W'(WORD_W) - width_i);
            rem   <= width_i - WID_W'(1);
        end else if (state == L_SHIFT && edge_i) begin
            if (rem == '0) begin
                shreg <= '0;
            end else begin
                shreg <= shreg << 1;
                rem   <= rem - WID_W'(1);
            end
        end
    end

    assign bit_o = shreg[WORD_W-1];

    // R5: an idle lane never drives the line
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == L_IDLE) |-> !bit_o);
endmodule

// File: rtl/pas_rx_lane.sv
`timescale 1ns/1ps
module pas_rx_lane
    import pas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              start_i,
    input  logic [WID_W-1:0]  width_i,
    input  logic              sdi_i,
    output logic              done_o,
    output logic [WORD_W-1:0] data_o
);
    lane_state_e       state, nxt;
    logic [WORD_W-1:0] shreg;
    logic [WID_W-1:0]  rem;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= L_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            L_IDLE:  if (start_i) nxt = L_SHIFT;
            L_SHIFT: if (edge_i && !start_i && rem == WID_W'(1)) nxt = L_IDLE;
            default: nxt = L_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            rem    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                shreg <= {{(WORD_W-1){1'b0}}, sdi_i};
                rem   <= width_i - WID_W'(1);
            end else if (state == L_SHIFT && edge_i) begin
                shreg <= {shreg[WORD_W-2:0], sdi_i};
                rem   <= rem - WID_W'(1);
                if (rem == WID_W'(1)) done_o <= 1'b1;
            end
        end
    end

    assign data_o = shreg;

    // R6: completion is a single pulse and only follows shifting
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r6_done_from_shift: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state) == L_SHIFT));
endmodule

// File: rtl/pos_audio_shifter.sv
`timescale 1ns/1ps
module pos_audio_shifter
    import pas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  bit_cnt,
    input  logic              tx_edge,
    input  logic              rx_edge,
    input  logic [WORD_W-1:0] tx_cfg,
    input  logic [WORD_W-1:0] rx_cfg,
    input  logic              tx_pack,
    input  logic              rx_pack,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_word_valid,
    output logic              tx_take,
    output logic              tx_underrun,
    output logic              sdo,
    input  logic              sdi,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    chan_cfg_t         txc [N_CH];
    chan_cfg_t         rxc [N_CH];
    logic [WID_W-1:0]  tx_w [N_CH];
    logic [WID_W-1:0]  rx_w [N_CH];
    logic [WORD_W-1:0] tx_samp [N_CH];
    logic [WORD_W-1:0] rx_data [N_CH];
    logic [N_CH-1:0]   tx_start, rx_start, tx_bits, rx_done;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign txc[i]  = tx_cfg[WORD_W-1-i*HALF_W -: HALF_W];
        assign rxc[i]  = rx_cfg[WORD_W-1-i*HALF_W -: HALF_W];
        assign tx_w[i] = chan_width(txc[i]);
        assign rx_w[i] = chan_width(rxc[i]);
        assign tx_start[i] = tx_edge && txc[i].en && (bit_cnt == txc[i].pos);
        assign rx_start[i] = rx_edge && rxc[i].en && (bit_cnt == rxc[i].pos);

        pas_tx_lane u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_i   (tx_edge),
            .start_i  (tx_start[i]),
            .width_i  (tx_w[i]),
            .sample_i (tx_samp[i]),
            .bit_o    (tx_bits[i])
        );

        pas_rx_lane u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_i  (rx_edge),
            .start_i (rx_start[i]),
            .width_i (rx_w[i]),
            .sdi_i   (sdi),
            .done_o  (rx_done[i]),
            .data_o  (rx_data[i])
        );
    end

    assign sdo = |tx_bits;

    // ---------------- transmit word fetch ----------------
    logic              tx_first1, need1, need2, under_d;
    logic [WORD_W-1:0] tx_hold;

    always_comb begin
        tx_first1 = txc[0].en && (!txc[1].en || (txc[0].pos <= txc[1].pos));
        need1     = tx_start[0] && (!tx_pack || tx_first1);
        need2     = tx_start[1] && (!tx_pack || !tx_first1);
        tx_take   = (need1 || need2) && tx_word_valid;
        under_d   = (need1 && !tx_word_valid) ||
                    (need2 && (!tx_word_valid || need1));
        if (tx_pack) begin
            tx_samp[0] = tx_first1
                ? (tx_word_valid ? {{HALF_W{1'b0}}, tx_word[HALF_W-1:0]} : '0)
                : {{HALF_W{1'b0}}, tx_hold[HALF_W-1:0]};
            tx_samp[1] = !tx_first1
                ? (tx_word_valid ? {{HALF_W{1'b0}}, tx_word[WORD_W-1:HALF_W]} : '0)
                : {{HALF_W{1'b0}}, tx_hold[WORD_W-1:HALF_W]};
        end else begin
            tx_samp[0] = tx_word_valid ? tx_word : '0;
            tx_samp[1] = (tx_word_valid && !need1) ? tx_word : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold     <= '0;
            tx_underrun <= 1'b0;
        end else begin
            tx_underrun <= under_d;
            if (tx_pack && (need1 || need2))
                tx_hold <= tx_word_valid ? tx_word : '0;
        end
    end

    // ---------------- receive word assembly ----------------
    logic              rx_first1, last1, last2;
    logic [HALF_W-1:0] half1, half2;

    always_comb begin
        rx_first1 = rxc[0].en && (!rxc[1].en || (rxc[0].pos <= rxc[1].pos));
        last1     = rxc[0].en && (!rxc[1].en || !rx_first1);
        last2     = rxc[1].en && (!rxc[0].en || rx_first1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_word  <= '0;
            half1    <= '0;
            half2    <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!rx_pack) begin
                half1 <= '0;
                half2 <= '0;
                if (rx_done[0]) begin
                    rx_valid <= 1'b1;
                    rx_word  <= rx_data[0];
                end else if (rx_done[1]) begin
                    rx_valid <= 1'b1;
                    rx_word  <= rx_data[1];
                end
            end else begin
                if (rx_done[0]) half1 <= rx_data[0][HALF_W-1:0];
                if (rx_done[1]) half2 <= rx_data[1][HALF_W-1:0];
                if ((rx_done[0] && last1) || (rx_done[1] && last2)) begin
                    rx_valid <= 1'b1;
                    rx_word  <= {rx_done[1] ? rx_data[1][HALF_W-1:0] : half2,
                                 rx_done[0] ? rx_data[0][HALF_W-1:0] : half1};
                    half1    <= '0;
                    half2    <= '0;
                end
            end
        end
    end

    // R10: a word is consumed only when one is offered
    a_r10_take_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> tx_word_valid);
    // R10: an underrun pulse follows a launch strobe
    a_r10_underrun_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> $past(tx_edge));
    // R6 / R9: every output word follows a lane completion
    a_r9_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(|rx_done));
endmodule

// File: tb/pos_audio_shifter_test.sv
`timescale 1ns/1ps
module pos_audio_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  bit_cnt;
    logic        tx_edge, rx_edge;
    logic [31:0] tx_cfg, rx_cfg;
    logic        tx_pack, rx_pack;
    logic [31:0] tx_word;
    logic        tx_word_valid;
    logic        tx_take, tx_underrun, sdo, sdi, rx_valid;
    logic [31:0] rx_word;

    always #2.5 clk = ~clk;

    pos_audio_shifter uut (
        .clk(clk), .rst_n(rst_n), .bit_cnt(bit_cnt),
        .tx_edge(tx_edge), .rx_edge(rx_edge),
        .tx_cfg(tx_cfg), .rx_cfg(rx_cfg),
        .tx_pack(tx_pack), .rx_pack(rx_pack),
        .tx_word(tx_word), .tx_word_valid(tx_word_valid),
        .tx_take(tx_take), .tx_underrun(tx_underrun),
        .sdo(sdo), .sdi(sdi), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] words [4];
    int          nwords, widx;
    logic [31:0] es [2];
    logic [31:0] rs [2];
    logic        sdi_fill;
    logic [31:0] exp_rx [4];
    int          n_exp_rx, exp_takes, exp_unders;
    logic [31:0] got_rx [8];
    int          n_got_rx, takes, unders;
    logic [63:0] eline, gline, sbits;

    function automatic logic [15:0] mk(bit en, bit ext, int code, int pos);
        return {ext, en, 10'(pos), 4'(code)};
    endfunction

    function automatic int wid(logic [15:0] h);
        int w;
        w = 8 + int'(h[3:0]) + (h[15] ? 16 : 0);
        if (w > 32) w = 32;
        return w;
    endfunction

    task automatic check(bit ok, string req, string what,
                         logic [63:0] got, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic observe();
        if (rx_valid) begin
            if (n_got_rx < 8) got_rx[n_got_rx] = rx_word;
            n_got_rx++;
        end
        if (tx_underrun) unders++;
    endtask

    task automatic drive_word();
        tx_word_valid = (widx < nwords);
        tx_word       = (widx < nwords) ? words[widx] : 32'h0;
    endtask

    task automatic run_frame(string req);
        logic [15:0] h;
        int w, p;
        bit took;
        eline = '0;
        sbits = sdi_fill ? {64{1'b1}} : 64'h0;
        for (int c = 0; c < 2; c++) begin
            h = (c == 0) ? tx_cfg[31:16] : tx_cfg[15:0];
            if (h[14]) begin
                w = wid(h); p = int'(h[13:4]);
                for (int k = 0; k < w; k++)
                    if (p + k < 64) eline[p+k] = es[c][w-1-k];
            end
            h = (c == 0) ? rx_cfg[31:16] : rx_cfg[15:0];
            if (h[14]) begin
                w = wid(h); p = int'(h[13:4]);
                for (int k = 0; k < w; k++)
                    if (p + k < 64) sbits[p+k] = rs[c][w-1-k];
            end
        end
        widx = 0; takes = 0; unders = 0; n_got_rx = 0;
        for (int b = 0; b < 64; b++) begin
            @(negedge clk);
            observe();
            bit_cnt = 10'(b); tx_edge = 1'b1; rx_edge = 1'b1; sdi = sbits[b];
            drive_word();
            #1 took = tx_take;
            if (took) takes++;
            @(posedge clk);
            if (took) widx++;
            @(negedge clk);
            observe();
            gline[b] = sdo;
            tx_edge = 1'b0; rx_edge = 1'b0;
            drive_word();
            @(posedge clk);
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            observe();
        end
        check(gline == eline, req, "serial line", gline, eline);
        check(takes == exp_takes, req, "words taken", 64'(takes), 64'(exp_takes));
        check(unders == exp_unders, req, "underrun pulses", 64'(unders), 64'(exp_unders));
        check(n_got_rx == n_exp_rx, req, "rx word count", 64'(n_got_rx), 64'(n_exp_rx));
        for (int i = 0; i < n_exp_rx && i < n_got_rx; i++)
            check(got_rx[i] == exp_rx[i], req, "rx word", 64'(got_rx[i]), 64'(exp_rx[i]));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(sdo == 1'b0, "R12", "sdo after reset", 64'(sdo), 64'h0);
        check(rx_valid == 1'b0, "R12", "rx_valid after reset", 64'(rx_valid), 64'h0);
        check(tx_underrun == 1'b0, "R12", "underrun after reset", 64'(tx_underrun), 64'h0);
        check(tx_take == 1'b0, "R12", "take after reset", 64'(tx_take), 64'h0);
    endtask

    // R1 R2 R3 R4 R6: unpacked, two channels of different widths
    task automatic t_unpacked();
        tx_pack = 0; rx_pack = 0; sdi_fill = 1;
        tx_cfg = {mk(1, 0, 8, 1), mk(1, 1, 0, 33)};
        rx_cfg = tx_cfg;
        words[0] = 32'h1234ABCD; words[1] = 32'h00C0FFEE; nwords = 2;
        es[0] = 32'hABCD; es[1] = 32'hC0FFEE;
        rs[0] = 32'h5A5A; rs[1] = 32'h123456;
        exp_rx[0] = 32'h00005A5A; exp_rx[1] = 32'h00123456; n_exp_rx = 2;
        exp_takes = 2; exp_unders = 0;
        run_frame("R4/R6 unpacked");
    endtask

    // R3: full 32-bit width and clamped over-range code
    task automatic t_width32();
        tx_pack = 0; rx_pack = 0; sdi_fill = 0;
        tx_cfg = {mk(1, 1, 8, 0), mk(1, 1, 15, 32)};
        rx_cfg = tx_cfg;
        words[0] = 32'h89ABCDEF; words[1] = 32'h13579BDF; nwords = 2;
        es[0] = 32'h89ABCDEF; es[1] = 32'h13579BDF;
        rs[0] = 32'hFEDCBA98; rs[1] = 32'h0F1E2D3C;
        exp_rx[0] = 32'hFEDCBA98; exp_rx[1] = 32'h0F1E2D3C; n_exp_rx = 2;
        exp_takes = 2; exp_unders = 0;
        run_frame("R3 width 32");
    endtask

    // R5 R7: disabled channel quiet and capturing nothing
    task automatic t_disabled();
        tx_pack = 0; rx_pack = 0; sdi_fill = 1;
        tx_cfg = {mk(1, 0, 0, 5), mk(0, 0, 0, 20)};
        rx_cfg = tx_cfg;
        words[0] = 32'hFFFFFF3C; words[1] = 32'hFFFFFFFF; nwords = 2;
        es[0] = 32'h3C; es[1] = 32'h0;
        rs[0] = 32'hFF; rs[1] = 32'h0;
        exp_rx[0] = 32'h000000FF; n_exp_rx = 1;
        exp_takes = 1; exp_unders = 0;
        run_frame("R5/R7 disabled");
    endtask

    // R8 R9: packed, channel 1 first
    task automatic t_packed();
        tx_pack = 1; rx_pack = 1; sdi_fill = 0;
        tx_cfg = {mk(1, 0, 8, 1), mk(1, 0, 8, 17)};
        rx_cfg = tx_cfg;
        words[0] = 32'hBEEF1234; words[1] = 32'h77777777; nwords = 2;
        es[0] = 32'h1234; es[1] = 32'hBEEF;
        rs[0] = 32'hA1B2; rs[1] = 32'hC3D4;
        exp_rx[0] = 32'hC3D4A1B2; n_exp_rx = 1;
        exp_takes = 1; exp_unders = 0;
        run_frame("R8/R9 packed");
    endtask

    // R8 R9: packed, channel 2 first with a 12-bit width
    task automatic t_packed_rev();
        tx_pack = 1; rx_pack = 1; sdi_fill = 0;
        tx_cfg = {mk(1, 0, 8, 40), mk(1, 0, 4, 8)};
        rx_cfg = tx_cfg;
        words[0] = 32'h0ABC7777; nwords = 1;
        es[0] = 32'h7777; es[1] = 32'hABC;
        rs[0] = 32'h4321; rs[1] = 32'hDEF;
        exp_rx[0] = 32'h0DEF4321; n_exp_rx = 1;
        exp_takes = 1; exp_unders = 0;
        run_frame("R8/R9 packed reversed");
    endtask

    // R10: no words offered
    task automatic t_underrun();
        tx_pack = 0; rx_pack = 0; sdi_fill = 1;
        tx_cfg = {mk(1, 0, 8, 1), mk(1, 1, 0, 33)};
        rx_cfg = 32'h0;
        nwords = 0;
        es[0] = 32'h0; es[1] = 32'h0;
        rs[0] = 32'h0; rs[1] = 32'h0;
        n_exp_rx = 0;
        exp_takes = 0; exp_unders = 2;
        run_frame("R10 underrun");
    endtask

    // R11: packed transmit alongside unpacked receive with another layout
    task automatic t_independent();
        tx_pack = 1; rx_pack = 0; sdi_fill = 1;
        tx_cfg = {mk(1, 0, 8, 1), mk(1, 0, 8, 17)};
        rx_cfg = {mk(1, 0, 0, 2), mk(1, 0, 2, 40)};
        words[0] = 32'h5555AAAA; nwords = 1;
        es[0] = 32'hAAAA; es[1] = 32'h5555;
        rs[0] = 32'h81; rs[1] = 32'h2AA;
        exp_rx[0] = 32'h81; exp_rx[1] = 32'h2AA; n_exp_rx = 2;
        exp_takes = 1; exp_unders = 0;
        run_frame("R11 independent");
    endtask

    initial begin
        rst_n = 1'b0; bit_cnt = '0; tx_edge = 0; rx_edge = 0;
        tx_cfg = '0; rx_cfg = '0; tx_pack = 0; rx_pack = 0;
        tx_word = '0; tx_word_valid = 0; sdi = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_unpacked();
        t_width32();
        t_disabled();
        t_packed();
        t_packed_rev();
        t_underrun();
        t_independent();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule